// File: doc/BRIEF.md
# Byte-Addressed Colour Palette Lookup

The block is a 256-entry colour lookup table for a pseudocolour display path. A host reaches it through a narrow byte bus. First it loads a 16-bit internal pointer with two byte writes, low byte and then high byte. It then streams colour components through one data register. A phase counter inside the block steps through red, green and blue. A palette entry is updated in one step when its blue byte arrives. After that the pointer moves to the next entry, so a run of entries can be loaded without setting the address again.

The same pointer space also holds a small bank of byte-wide control registers, starting at 0x0300. The host reaches them through a separate control data register. The register at 0x0300 governs the hardware cursor, and the block reports its state as a cursor enable. On the display side, an 8-bit pixel index enters each clock and the 24-bit RGB colour of that entry leaves one clock later.

Top module: `palette_lut`

## Requirements
- R1: A write with `bus_sel` = 0 loads the pointer's low byte from `bus_wdata` and returns the colour phase to red. A read with `bus_sel` = 0 returns the low byte one clock later.
- R2: A write with `bus_sel` = 1 loads the pointer's high byte and returns the phase to red. A read with `bus_sel` = 1 returns the high byte.
- R3: Writes with `bus_sel` = 3 take red, green and blue in that order. The palette entry is updated only on the blue write, as {red, green, blue} in `pix_rgb` bits 23:16, 15:8 and 7:0. Until then the lookup still shows the old colour.
- R4: After the blue write, or after the blue read, the 16-bit pointer increases by one and the phase returns to red. A carry passes into the high byte, so 0x00FF is followed by 0x0100.
- R5: Colour writes while the pointer's high byte is non-zero leave every palette entry unchanged.
- R6: Reads with `bus_sel` = 3 return the red, green and blue bytes of the addressed entry in phase order, one clock after each read. Outside the palette range these reads return 0.
- R7: `pix_rgb` shows the entry selected by `pix_idx` one clock after `pix_idx` is presented.
- R8: With `bus_sel` = 2, accesses write or read the control register at the pointer. Control registers sit at 0x0300 to 0x0303. Register 0x0300 resets to 0x40, and `cursor_en` is high while that register is non-zero, so writing 0x00 there turns the cursor off. Control accesses do not move the pointer.
- R9: After reset the pointer is 0x0000, the phase is red, `bus_rdata` and `pix_rgb` are 0, and `cursor_en` is 1.
- R10: Control writes to a pointer outside 0x0300 to 0x0303 have no effect, and control reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when `bus_wr` is high) |
| bus_sel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 control data, 3 colour data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after the read strobe |
| pix_idx | input | 8 | Pixel palette index |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |
| cursor_en | output | 1 | High while cursor control register is non-zero |

## Verification
The bench builds the block with its default values: an 8-bit index, four control registers at 0x0300, and a cursor reset value of 0x40. These values let the bench reach the pointer carry from 0x00FF to 0x0100 after a two-entry burst. From there it checks that colour writes land outside the palette and are discarded. With four control registers the bench can also probe both the upper edge of the control bank (0x0304) and the address just below it (0x02FF).

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int          IDX_W      = 8,
  parameter int          N_CTRL     = 4,
  parameter logic [15:0] CTRL_BASE  = 16'h0300,
  parameter logic [7:0]  CURSOR_RST = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_sel,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [23:0]      pix_rgb,
  output logic             cursor_en
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;

  logic [15:0] addr;
  logic [1:0]  phase;
  logic [7:0]  hold_r, hold_g;
  logic [23:0] mem [DEPTH];
  logic [7:0]  ctrl [N_CTRL];

  logic [15:0] ctrl_off;
  logic        pal_hit, ctrl_hit, cmap_wr, cmap_rd, step;
  logic [23:0] entry;
  logic [7:0]  comp;

  assign pal_hit  = (addr >> IDX_W) == 16'd0;
  assign ctrl_off = addr - CTRL_BASE;
  assign ctrl_hit = (addr >= CTRL_BASE) && (ctrl_off < 16'(N_CTRL));
  assign cmap_wr  = bus_wr && bus_sel == 2'd3;
  assign cmap_rd  = bus_rd && !bus_wr && bus_sel == 2'd3;
  assign step     = cmap_wr || cmap_rd;
  assign entry    = mem[addr[IDX_W-1:0]];
  assign cursor_en = ctrl[0] != 8'h00;

  always_comb begin
    case (phase)
      2'd0:    comp = entry[23:16];
      2'd1:    comp = entry[15:8];
      2'd2:    comp = entry[7:0];
      default: comp = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr      <= 16'h0000;
      phase     <= 2'd0;
      hold_r    <= 8'h00;
      hold_g    <= 8'h00;
      bus_rdata <= 8'h00;
      for (int i = 0; i < N_CTRL; i++) ctrl[i] <= (i == 0) ? CURSOR_RST : 8'h00;
    end else begin
      if (bus_wr) begin
        case (bus_sel)
          2'd0: begin addr[7:0]  <= bus_wdata; phase <= 2'd0; end
          2'd1: begin addr[15:8] <= bus_wdata; phase <= 2'd0; end
          2'd2: if (ctrl_hit) ctrl[ctrl_off[CW-1:0]] <= bus_wdata;
          default: begin
            if (phase == 2'd0) hold_r <= bus_wdata;
            if (phase == 2'd1) hold_g <= bus_wdata;
          end
        endcase
      end else if (bus_rd) begin
        case (bus_sel)
          2'd0:    bus_rdata <= addr[7:0];
          2'd1:    bus_rdata <= addr[15:8];
          2'd2:    bus_rdata <= ctrl_hit ? ctrl[ctrl_off[CW-1:0]] : 8'h00;
          default: bus_rdata <= pal_hit ? comp : 8'h00;
        endcase
      end
      if (step) begin
        if (phase == 2'd2) begin
          phase <= 2'd0;
          addr  <= addr + 16'd1;
        end else begin
          phase <= phase + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmap_wr && phase == 2'd2 && pal_hit)
      mem[addr[IDX_W-1:0]] <= {hold_r, hold_g, bus_wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= 24'h0;
    else        pix_rgb <= mem[pix_idx];
  end
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [1:0]  bus_sel,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [15:0] addr,
  input logic [1:0]  phase
);
  // R3
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  // R1
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd0) |=> (addr[7:0] == $past(bus_wdata) && phase == 2'd0));

  // R2
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1) |=> (addr[15:8] == $past(bus_wdata) && phase == 2'd0));

  // R4
  blue_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd3 && phase == 2'd2) |=> (phase == 2'd0 && addr == $past(addr) + 16'd1));

  // R3
  rg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd3 && phase != 2'd2) |=> (phase == $past(phase) + 2'd1 && $stable(addr)));

  // R8
  ctrl_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_sel == 2'd2) |=> ($stable(addr) && $stable(phase)));

  // R1
  lo_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == 2'd0) |=> (bus_rdata == $past(addr[7:0])));
endmodule

bind palette_lut palette_lut_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .addr(addr), .phase(phase)
);

// File: tb/test_palette_lut.sv
module test_palette_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  pix_idx = 8'h00;
  logic [23:0] pix_rgb;
  logic        cursor_en;

  int checks = 0, errors = 0;
  bit done = 0;
  bit rd_seen = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  palette_lut i_palette_lut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .cursor_en(cursor_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd && !bus_wr;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {24'h0, bus_rdata}, {24'h0, e});
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = s;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr(2'd0, a[7:0]);
    wr(2'd1, a[15:8]);
  endtask

  task automatic put_rgb(input logic [23:0] c);
    wr(2'd3, c[23:16]);
    wr(2'd3, c[15:8]);
    wr(2'd3, c[7:0]);
  endtask

  task automatic look(input logic [7:0] idx, input logic [23:0] exp, input string tag);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    check(tag, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rdata", {24'h0, bus_rdata}, 32'h0);
    check("R9 pix_rgb", {8'h0, pix_rgb}, 32'h0);
    check("R9 cursor_en", {31'h0, cursor_en}, 32'h1);
    rst_n = 1'b1;
    rd(2'd0, 8'h00, "R9 ptr low after reset");
    rd(2'd1, 8'h00, "R9 ptr high after reset");

    set_ptr(16'h0000);
    put_rgb(24'h0A0B0C);
    set_ptr(16'h0010);
    put_rgb(24'h010203);
    look(8'h10, 24'h010203, "R3 first entry");
    set_ptr(16'h0010);
    wr(2'd3, 8'hAA);
    wr(2'd3, 8'hBB);
    look(8'h10, 24'h010203, "R3 no commit before blue");
    wr(2'd3, 8'hCC);
    look(8'h10, 24'hAABBCC, "R3 commit on blue");
    rd(2'd0, 8'h11, "R4 pointer advanced");
    put_rgb(24'h112233);
    look(8'h11, 24'h112233, "R4 burst next entry");

    set_ptr(16'h0020);
    wr(2'd3, 8'h05);
    wr(2'd0, 8'h20);
    put_rgb(24'h070809);
    look(8'h20, 24'h070809, "R1 low write resets phase");
    set_ptr(16'h0021);
    wr(2'd3, 8'h06);
    wr(2'd1, 8'h00);
    put_rgb(24'h0D0E0F);
    look(8'h21, 24'h0D0E0F, "R2 high write resets phase");

    set_ptr(16'h00FE);
    put_rgb(24'hFEFEFE);
    put_rgb(24'hFFFFFF);
    rd(2'd0, 8'h00, "R4 carry low byte");
    rd(2'd1, 8'h01, "R4 carry high byte");
    look(8'hFF, 24'hFFFFFF, "R4 last entry");
    put_rgb(24'h999999);
    look(8'h00, 24'h0A0B0C, "R5 out of range write ignored");
    rd(2'd0, 8'h01, "R5 pointer still steps");

    set_ptr(16'h0010);
    rd(2'd3, 8'hAA, "R6 red");
    rd(2'd3, 8'hBB, "R6 green");
    rd(2'd3, 8'hCC, "R6 blue");
    rd(2'd0, 8'h11, "R6 read advances pointer");
    set_ptr(16'h0105);
    rd(2'd3, 8'h00, "R6 out of range read");

    @(negedge clk);
    pix_idx = 8'h10;
    @(negedge clk);
    pix_idx = 8'h11;
    #1;
    check("R7 old value before edge", {8'h0, pix_rgb}, 32'h00AABBCC);
    @(negedge clk);
    check("R7 one clock latency", {8'h0, pix_rgb}, 32'h00112233);

    set_ptr(16'h0300);
    rd(2'd2, 8'h40, "R8 cursor reset value");
    wr(2'd2, 8'h00);
    @(negedge clk);
    check("R8 cursor off", {31'h0, cursor_en}, 32'h0);
    rd(2'd2, 8'h00, "R8 cursor readback");
    wr(2'd2, 8'h01);
    @(negedge clk);
    check("R8 cursor on", {31'h0, cursor_en}, 32'h1);
    set_ptr(16'h0302);
    wr(2'd2, 8'h5A);
    rd(2'd2, 8'h5A, "R8 control register 2");
    rd(2'd0, 8'h02, "R8 pointer unchanged");

    set_ptr(16'h0304);
    wr(2'd2, 8'h77);
    rd(2'd2, 8'h00, "R10 above bank");
    set_ptr(16'h02FF);
    wr(2'd2, 8'h66);
    rd(2'd2, 8'h00, "R10 below bank");
    set_ptr(16'h0300);
    rd(2'd2, 8'h01, "R10 bank untouched");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule